// File: doc/BRIEF.md
# Memory Traffic Generator with Read-Back Checker

This block exercises a memory controller through its user-side FIFO ports. Once the controller reports that initialisation has finished, the generator writes one word to every address of a configurable window. Each word is a pattern derived from its own address. It then requests every address of the same window again and checks each returned word against a freshly regenerated copy of the pattern. Because the expected word depends only on the address, the checker needs no storage for what was written.

The command port carries an enable, a 32-bit address and a 3-bit operation code, and it can be stalled by a full flag. The write-data port carries an enable and a word, and it can also be stalled by a full flag. The read-data port has a pop enable and reports when it is empty. A mismatch raises a sticky error flag and records the address of the first failing word. A dedicated clear input resets both. When the last word has been compared, the block sits in a finished state and issues nothing more.

Top module: `mtg_traffic_gen`

## Requirements
- R1: No command enable and no write-data enable is asserted before `init_done_i` has been sampled high on a clock edge; the first command appears one cycle after that edge.
- R2: The operation code is 3'b000 for a write and 3'b001 for a read. No other code is driven while the command enable is high. Every write command and every write-data word of the window is accepted before the first read command is presented.
- R3: The window contains the addresses START_ADDR, START_ADDR+ADDR_STEP, and so on, up to the last address that does not pass END_ADDR. Command addresses advance by ADDR_STEP per accepted command. After the last address they wrap to START_ADDR, so both phases walk the window in ascending order.
- R4: While `cmd_full_i` is high and a command is presented, the next cycle keeps the command enable high with the same address and operation code.
- R5: While `wr_full_i` is high and a write word is presented, the next cycle keeps the write enable high with the same data word.
- R6: With PATTERN=0, the word for address a is computed as follows: s = a XOR SEED, and the word is (s>>1) XOR POLY when bit 0 of s is 1, otherwise s>>1. With PATTERN=1, the word is the address itself.
- R7: `rd_en_o` is high only while `rd_empty_i` is low and only during the read phase. Exactly one word is popped per window address.
- R8: A popped word that differs from the pattern for its address sets `err_o` from the next cycle on. The flag stays set until cleared. `err_addr_o` holds the address of the first mismatching word since reset or the last clear.
- R9: `err_clear_i` clears `err_o` and zeroes `err_addr_o`. If a mismatch occurs in the same cycle, the flag stays set and the address of that mismatch is recorded.
- R10: One cycle after the last word is popped, `done_o` goes high and stays high. From then on, no command, write word or pop is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done_i | input | 1 | Controller has finished initialisation |
| err_clear_i | input | 1 | Clears the error flag and failing address |
| cmd_en_o | output | 1 | Command valid, pushed into the controller command FIFO |
| cmd_addr_o | output | ADDR_W | Address of the current command |
| cmd_op_o | output | 3 | Operation code: 000 write, 001 read |
| cmd_full_i | input | 1 | Command FIFO cannot accept |
| wr_en_o | output | 1 | Write word valid |
| wr_data_o | output | DATA_W | Write word |
| wr_full_i | input | 1 | Write-data FIFO cannot accept |
| rd_en_o | output | 1 | Pop a word from the read-data FIFO |
| rd_data_i | input | DATA_W | Head word of the read-data FIFO |
| rd_empty_i | input | 1 | Read-data FIFO holds no word |
| err_o | output | 1 | Sticky mismatch flag |
| err_addr_o | output | ADDR_W | Address of the first mismatching word |
| done_o | output | 1 | Both phases have completed |

## Verification
On every cycle the assertions check the following: the gate on initialisation, the holding of commands and write words under a full flag, the legal operation codes, that addresses stay inside the window, that no pop is made from an empty FIFO, that the error flag is sticky and cleared correctly, and that the block is quiet once finished. Only the bench scenarios can show the rest. These are the exact order of addresses across the wrap between the two phases, the pattern value of every written word, the one-pop-per-address count, and which address is recorded as failing when several words are corrupted. The bench shows these by sweeping every combination of stall patterns on the three FIFOs against a memory model.

// File: rtl/mtg_pkg.sv
package mtg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_READ  = 2'd2,
      ST_DONE  = 2'd3
   } mtg_state_e;

   localparam logic [2:0] OP_WRITE = 3'b000;
   localparam logic [2:0] OP_READ  = 3'b001;

   // one right-shift Galois step from an address-derived seed
   function automatic logic [31:0] lfsr_word(input logic [31:0] addr,
                                             input logic [31:0] seed,
                                             input logic [31:0] poly);
      logic [31:0] s;
      s = addr ^ seed;
      return s[0] ? ((s >> 1) ^ poly) : (s >> 1);
   endfunction

endpackage

// File: rtl/mtg_pattern.sv
module mtg_pattern #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned PATTERN = 0,
   parameter logic [31:0] SEED    = 32'h6A09_E667,
   parameter logic [31:0] POLY    = 32'h8020_0003
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [DATA_W-1:0] data_o
);
   import mtg_pkg::*;

   generate
      if (PATTERN == 0) begin : g_lfsr
         logic [31:0] word;
         assign word   = lfsr_word(32'(addr_i), SEED, POLY);
         assign data_o = DATA_W'(word);
      end else begin : g_addr
         assign data_o = DATA_W'(addr_i);
      end
   endgenerate

endmodule

// File: rtl/mtg_addr_step.sv
module mtg_addr_step #(
   parameter int unsigned       ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] START_ADDR = '0,
   parameter logic [ADDR_W-1:0] END_ADDR   = '1,
   parameter int unsigned       ADDR_STEP  = 4
) (
   input  logic [ADDR_W-1:0] cur_i,
   output logic [ADDR_W-1:0] nxt_o,
   output logic              last_o
);
   localparam logic [ADDR_W:0] END_X  = {1'b0, END_ADDR};
   localparam logic [ADDR_W:0] STEP_X = (ADDR_W+1)'(ADDR_STEP);

   logic [ADDR_W:0] sum;

   assign sum    = {1'b0, cur_i} + STEP_X;
   assign last_o = (sum > END_X);
   assign nxt_o  = last_o ? START_ADDR : sum[ADDR_W-1:0];

endmodule

// File: rtl/mtg_rd_check.sv
module mtg_rd_check #(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       DATA_W     = 32,
   parameter logic [ADDR_W-1:0] START_ADDR = '0,
   parameter logic [ADDR_W-1:0] END_ADDR   = '1,
   parameter int unsigned       ADDR_STEP  = 4,
   parameter int unsigned       PATTERN    = 0,
   parameter logic [31:0]       SEED       = 32'h6A09_E667,
   parameter logic [31:0]       POLY       = 32'h8020_0003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              rd_empty_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              clear_i,
   output logic              rd_en_o,
   output logic              err_o,
   output logic [ADDR_W-1:0] err_addr_o,
   output logic              last_o
);
   logic [ADDR_W-1:0] exp_addr_q;
   logic [ADDR_W-1:0] exp_nxt;
   logic              exp_last;
   logic [DATA_W-1:0] exp_data;
   logic              fire;
   logic              miss;
   logic              err_q;
   logic [ADDR_W-1:0] err_addr_q;

   mtg_addr_step #(
      .ADDR_W(ADDR_W), .START_ADDR(START_ADDR),
      .END_ADDR(END_ADDR), .ADDR_STEP(ADDR_STEP)
   ) u_step (
      .cur_i(exp_addr_q), .nxt_o(exp_nxt), .last_o(exp_last)
   );

   mtg_pattern #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PATTERN(PATTERN),
      .SEED(SEED), .POLY(POLY)
   ) u_exp (
      .addr_i(exp_addr_q), .data_o(exp_data)
   );

   assign fire    = active_i & ~rd_empty_i;
   assign miss    = fire & (rd_data_i != exp_data);
   assign rd_en_o = fire;
   assign last_o  = fire & exp_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_addr_q <= START_ADDR;
         err_q      <= 1'b0;
         err_addr_q <= '0;
      end else begin
         if (fire) begin
            exp_addr_q <= exp_nxt;
         end
         if (miss) begin
            err_q <= 1'b1;
            if (!err_q || clear_i) begin
               err_addr_q <= exp_addr_q;
            end
         end else if (clear_i) begin
            err_q      <= 1'b0;
            err_addr_q <= '0;
         end
      end
   end

   assign err_o      = err_q;
   assign err_addr_o = err_addr_q;

endmodule

// File: rtl/mtg_traffic_gen.sv
module mtg_traffic_gen #(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       DATA_W     = 32,
   parameter logic [ADDR_W-1:0] START_ADDR = ADDR_W'(32'h0000_2000),
   parameter logic [ADDR_W-1:0] END_ADDR   = ADDR_W'(32'h0000_AFFF),
   parameter int unsigned       ADDR_STEP  = 4,
   parameter int unsigned       PATTERN    = 0,
   parameter logic [31:0]       SEED       = 32'h6A09_E667,
   parameter logic [31:0]       POLY       = 32'h8020_0003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_done_i,
   input  logic              err_clear_i,
   output logic              cmd_en_o,
   output logic [ADDR_W-1:0] cmd_addr_o,
   output logic [2:0]        cmd_op_o,
   input  logic              cmd_full_i,
   output logic              wr_en_o,
   output logic [DATA_W-1:0] wr_data_o,
   input  logic              wr_full_i,
   output logic              rd_en_o,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              rd_empty_i,
   output logic              err_o,
   output logic [ADDR_W-1:0] err_addr_o,
   output logic              done_o
);
   import mtg_pkg::*;

   localparam logic [ADDR_W:0]   SPAN      = {1'b0, END_ADDR} - {1'b0, START_ADDR} + (ADDR_W+1)'(1);
   localparam logic [ADDR_W:0]   STEP_X    = (ADDR_W+1)'(ADDR_STEP);
   localparam logic [ADDR_W-1:0] ALIGN_MSK = ADDR_W'(ADDR_STEP - 1);

   // elaboration-time parameter checks
   generate
      if (ADDR_W > 32 || ADDR_W < 2) begin : g_bad_aw
         $error("mtg_traffic_gen: ADDR_W must be 2..32");
      end
      if (ADDR_STEP == 0 || (ADDR_STEP & (ADDR_STEP - 1)) != 0) begin : g_bad_step
         $error("mtg_traffic_gen: ADDR_STEP must be a power of two");
      end
      if (END_ADDR < START_ADDR) begin : g_bad_win
         $error("mtg_traffic_gen: END_ADDR below START_ADDR");
      end
      if ((START_ADDR & ALIGN_MSK) != '0) begin : g_bad_align
         $error("mtg_traffic_gen: START_ADDR not step aligned");
      end
      if ((SPAN % STEP_X) != '0) begin : g_bad_span
         $error("mtg_traffic_gen: window not a whole number of steps");
      end
      if (PATTERN > 1) begin : g_bad_pat
         $error("mtg_traffic_gen: PATTERN must be 0 or 1");
      end
      if (PATTERN == 0 && DATA_W != 32) begin : g_bad_dw
         $error("mtg_traffic_gen: LFSR pattern needs DATA_W of 32");
      end
   endgenerate

   mtg_state_e        state_q;
   logic              cmd_en_q;
   logic              wr_en_q;
   logic [ADDR_W-1:0] addr_q;
   logic [2:0]        op_q;
   logic [ADDR_W-1:0] addr_nxt;
   logic              addr_last;
   logic              cmd_left;
   logic              wd_left;
   logic              chk_last;
   logic              rd_active;

   mtg_addr_step #(
      .ADDR_W(ADDR_W), .START_ADDR(START_ADDR),
      .END_ADDR(END_ADDR), .ADDR_STEP(ADDR_STEP)
   ) u_cmd_step (
      .cur_i(addr_q), .nxt_o(addr_nxt), .last_o(addr_last)
   );

   mtg_pattern #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PATTERN(PATTERN),
      .SEED(SEED), .POLY(POLY)
   ) u_wr_pat (
      .addr_i(addr_q), .data_o(wr_data_o)
   );

   assign rd_active = (state_q == ST_READ);

   mtg_rd_check #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .START_ADDR(START_ADDR),
      .END_ADDR(END_ADDR), .ADDR_STEP(ADDR_STEP), .PATTERN(PATTERN),
      .SEED(SEED), .POLY(POLY)
   ) u_check (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (rd_active),
      .rd_empty_i (rd_empty_i),
      .rd_data_i  (rd_data_i),
      .clear_i    (err_clear_i),
      .rd_en_o    (rd_en_o),
      .err_o      (err_o),
      .err_addr_o (err_addr_o),
      .last_o     (chk_last)
   );

   // still owed after this edge: presented but refused
   assign cmd_left = cmd_en_q & cmd_full_i;
   assign wd_left  = wr_en_q & wr_full_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cmd_en_q <= 1'b0;
         wr_en_q  <= 1'b0;
         addr_q   <= START_ADDR;
         op_q     <= OP_WRITE;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (init_done_i) begin
                  state_q  <= ST_WRITE;
                  cmd_en_q <= 1'b1;
                  wr_en_q  <= 1'b1;
                  addr_q   <= START_ADDR;
                  op_q     <= OP_WRITE;
               end
            end
            ST_WRITE: begin
               if (!cmd_left && !wd_left) begin
                  if (addr_last) begin
                     state_q  <= ST_READ;
                     addr_q   <= START_ADDR;
                     op_q     <= OP_READ;
                     cmd_en_q <= 1'b1;
                     wr_en_q  <= 1'b0;
                  end else begin
                     addr_q   <= addr_nxt;
                     cmd_en_q <= 1'b1;
                     wr_en_q  <= 1'b1;
                  end
               end else begin
                  cmd_en_q <= cmd_left;
                  wr_en_q  <= wd_left;
               end
            end
            ST_READ: begin
               if (cmd_en_q && !cmd_full_i) begin
                  if (addr_last) begin
                     cmd_en_q <= 1'b0;
                  end else begin
                     addr_q <= addr_nxt;
                  end
               end
               if (chk_last) begin
                  state_q  <= ST_DONE;
                  cmd_en_q <= 1'b0;
               end
            end
            default: begin
               cmd_en_q <= 1'b0;
               wr_en_q  <= 1'b0;
            end
         endcase
      end
   end

   assign cmd_en_o   = cmd_en_q;
   assign cmd_addr_o = addr_q;
   assign cmd_op_o   = op_q;
   assign wr_en_o    = wr_en_q;
   assign done_o     = (state_q == ST_DONE);

endmodule

// File: rtl/mtg_traffic_gen_sva.sv
module mtg_traffic_gen_sva #(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       DATA_W     = 32,
   parameter logic [ADDR_W-1:0] START_ADDR = '0,
   parameter logic [ADDR_W-1:0] END_ADDR   = '1,
   parameter int unsigned       ADDR_STEP  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              init_done_i,
   input logic              err_clear_i,
   input logic              cmd_en_o,
   input logic [ADDR_W-1:0] cmd_addr_o,
   input logic [2:0]        cmd_op_o,
   input logic              cmd_full_i,
   input logic              wr_en_o,
   input logic [DATA_W-1:0] wr_data_o,
   input logic              wr_full_i,
   input logic              rd_en_o,
   input logic              rd_empty_i,
   input logic              err_o,
   input logic              done_o
);
   localparam logic [ADDR_W-1:0] ALIGN_MSK = ADDR_W'(ADDR_STEP - 1);

   logic init_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           init_seen <= 1'b0;
      else if (init_done_i) init_seen <= 1'b1;
   end

   AST_INIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !init_seen |-> (!cmd_en_o && !wr_en_o));                              // R1

   AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_en_o |-> (cmd_op_o == 3'b000 || cmd_op_o == 3'b001));             // R2

   AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_en_o |-> (cmd_addr_o >= START_ADDR && cmd_addr_o <= END_ADDR
                    && (cmd_addr_o & ALIGN_MSK) == '0));                    // R3

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_en_o && cmd_full_i) |=> (cmd_en_o && $stable(cmd_addr_o)
                                    && $stable(cmd_op_o)));                 // R4

   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && wr_full_i) |=> (wr_en_o && $stable(wr_data_o)));          // R5

   AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |-> !rd_empty_i);                                             // R7

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !err_clear_i) |=> err_o);                                   // R8

   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clear_i && !rd_en_o) |=> !err_o);                                // R9

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!cmd_en_o && !wr_en_o && !rd_en_o));                      // R10

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o);                                                   // R10

endmodule

bind mtg_traffic_gen mtg_traffic_gen_sva #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .START_ADDR(START_ADDR),
   .END_ADDR(END_ADDR), .ADDR_STEP(ADDR_STEP)
) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .init_done_i (init_done_i),
   .err_clear_i (err_clear_i),
   .cmd_en_o    (cmd_en_o),
   .cmd_addr_o  (cmd_addr_o),
   .cmd_op_o    (cmd_op_o),
   .cmd_full_i  (cmd_full_i),
   .wr_en_o     (wr_en_o),
   .wr_data_o   (wr_data_o),
   .wr_full_i   (wr_full_i),
   .rd_en_o     (rd_en_o),
   .rd_empty_i  (rd_empty_i),
   .err_o       (err_o),
   .done_o      (done_o)
);

// File: tb/mtg_traffic_gen_bench.sv
module mtg_traffic_gen_bench;

   localparam logic [31:0] B_START = 32'h0000_0100;
   localparam logic [31:0] B_END   = 32'h0000_013F;
   localparam int          B_STEP  = 4;
   localparam int          NW      = 16;
   localparam logic [31:0] B_SEED  = 32'h6A09_E667;
   localparam logic [31:0] B_POLY  = 32'h8020_0003;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_done = 1'b0;
   logic        err_clear = 1'b0;
   logic        cmd_en;
   logic [31:0] cmd_addr;
   logic [2:0]  cmd_op;
   logic        cmd_full = 1'b0;
   logic        wr_en;
   logic [31:0] wr_data;
   logic        wr_full = 1'b0;
   logic        rd_en;
   logic [31:0] rd_data = '0;
   logic        rd_empty = 1'b1;
   logic        err;
   logic [31:0] err_addr;
   logic        done;

   int checks = 0;
   int errors = 0;
   int total_cycles = 0;

   always #4 clk = ~clk;

   mtg_traffic_gen #(
      .ADDR_W(32), .DATA_W(32), .START_ADDR(B_START), .END_ADDR(B_END),
      .ADDR_STEP(B_STEP), .PATTERN(0), .SEED(B_SEED), .POLY(B_POLY)
   ) u_mtg_traffic_gen (
      .clk(clk), .rst_n(rst_n), .init_done_i(init_done), .err_clear_i(err_clear),
      .cmd_en_o(cmd_en), .cmd_addr_o(cmd_addr), .cmd_op_o(cmd_op), .cmd_full_i(cmd_full),
      .wr_en_o(wr_en), .wr_data_o(wr_data), .wr_full_i(wr_full),
      .rd_en_o(rd_en), .rd_data_i(rd_data), .rd_empty_i(rd_empty),
      .err_o(err), .err_addr_o(err_addr), .done_o(done)
   );

   // expected pattern, from the formula in R6
   function automatic logic [31:0] pat(input logic [31:0] a);
      logic [31:0] s;
      s = a ^ B_SEED;
      if (s[0]) return (s >> 1) ^ B_POLY;
      return s >> 1;
   endfunction

   function automatic bit stall_of(input int mode, input int cyc, input int salt);
      case (mode)
         0: return 1'b0;
         1: return ((cyc + salt) % 3) == 0;
         2: return (((cyc * 7 + salt * 13) ^ (cyc >> 2)) % 5) < 2;
         default: return ((cyc + salt) % 16) < 6;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      total_cycles++;
      if (total_cycles > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   logic [31:0] mem [NW];

   task automatic run_case(input int cm, input int wm, input int rs,
                           input int bad0, input int bad1, input bit do_clear);
      logic [31:0] rdq[$];
      logic [31:0] wc_q[$];
      logic [31:0] wd_q[$];
      logic [31:0] pa_q[$];
      int          pd_q[$];
      int cyc = 0;
      int wcmds = 0, wwords = 0, rcmds = 0, pops = 0;
      bit p_cen = 0, p_cfull = 0, p_wen = 0, p_wfull = 0;
      logic [31:0] p_addr = '0, p_wdata = '0;
      logic [2:0]  p_op = '0;
      bit hung = 0;

      for (int i = 0; i < NW; i++) mem[i] = '0;
      @(negedge clk);
      rst_n = 1'b0; init_done = 1'b0; err_clear = 1'b0;
      cmd_full = 1'b0; wr_full = 1'b0; rd_empty = 1'b1; rd_data = '0;
      repeat (2) @(negedge clk);
      #1;
      check(!cmd_en && !wr_en && !rd_en && !err && !done, "R10", "reset state quiet",
            {27'd0, cmd_en, wr_en, rd_en, err, done}, 32'd0);
      check(err_addr == 32'd0, "R8", "reset failing address", err_addr, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: hold init low, nothing may be issued
      for (int k = 0; k < 6; k++) begin
         @(negedge clk); #1;
         check(!cmd_en && !wr_en, "R1", "issue before init",
               {30'd0, cmd_en, wr_en}, 32'd0);
      end
      init_done = 1'b1;

      forever begin
         @(negedge clk);
         cyc++;
         while (pa_q.size() > 0 && pd_q[0] <= cyc) begin
            rdq.push_back(mem[(pa_q[0] - B_START) / B_STEP]);
            void'(pa_q.pop_front());
            void'(pd_q.pop_front());
         end
         cmd_full = stall_of(cm, cyc, 0);
         wr_full  = stall_of(wm, cyc, 5);
         rd_empty = (rdq.size() == 0) || (rs != 0 && stall_of(2, cyc, 9));
         rd_data  = (rdq.size() > 0) ? rdq[0] : 32'd0;
         #1;
         if (p_cen && p_cfull)
            check(cmd_en && cmd_addr == p_addr && cmd_op == p_op, "R4",
                  "command held under full", cmd_addr, p_addr);
         if (p_wen && p_wfull)
            check(wr_en && wr_data == p_wdata, "R5", "write word held under full",
                  wr_data, p_wdata);
         if (rd_en)
            check(!rd_empty, "R7", "pop while empty", {31'd0, rd_empty}, 32'd0);
         if (cmd_en && !cmd_full) begin
            if (cmd_op == 3'b000) begin
               check(rcmds == 0, "R2", "write after read began", rcmds, 0);
               check(cmd_addr == B_START + wcmds * B_STEP, "R3", "write address order",
                     cmd_addr, B_START + wcmds * B_STEP);
               wc_q.push_back(cmd_addr);
               wcmds++;
            end else if (cmd_op == 3'b001) begin
               check(wcmds == NW && wwords == NW, "R2", "read before writes done",
                     wwords, NW);
               check(cmd_addr == B_START + rcmds * B_STEP, "R3", "read address order",
                     cmd_addr, B_START + rcmds * B_STEP);
               pa_q.push_back(cmd_addr);
               pd_q.push_back(cyc + 3);
               rcmds++;
            end else begin
               check(1'b0, "R2", "illegal op code", {29'd0, cmd_op}, 32'd1);
            end
         end
         if (wr_en && !wr_full) begin
            check(wr_data == pat(B_START + wwords * B_STEP), "R6", "write pattern",
                  wr_data, pat(B_START + wwords * B_STEP));
            wd_q.push_back(wr_data);
            wwords++;
         end
         while (wc_q.size() > 0 && wd_q.size() > 0) begin
            automatic int idx = (wc_q[0] - B_START) / B_STEP;
            automatic logic [31:0] v = wd_q[0];
            if (idx == bad0 || idx == bad1) v = v ^ 32'h0000_0001;
            if (idx >= 0 && idx < NW) mem[idx] = v;
            void'(wc_q.pop_front());
            void'(wd_q.pop_front());
         end
         if (rd_en) begin
            void'(rdq.pop_front());
            pops++;
         end
         p_cen = cmd_en; p_cfull = cmd_full; p_addr = cmd_addr; p_op = cmd_op;
         p_wen = wr_en; p_wfull = wr_full; p_wdata = wr_data;
         if (done) break;
         if (cyc > 4000) begin
            hung = 1;
            break;
         end
      end

      check(!hung, "R10", "run reached done", cyc, 4000);
      check(wcmds == NW && rcmds == NW, "R3", "one command per window address",
            wcmds + rcmds, 2 * NW);
      check(pops == NW, "R7", "one pop per window address", pops, NW);
      if (bad0 >= 0) begin
         check(err == 1'b1, "R8", "mismatch flagged", {31'd0, err}, 32'd1);
         check(err_addr == B_START + bad0 * B_STEP, "R8", "first failing address",
               err_addr, B_START + bad0 * B_STEP);
      end else begin
         check(err == 1'b0, "R8", "clean run no error", {31'd0, err}, 32'd0);
      end
      cmd_full = 1'b0; wr_full = 1'b0;
      rd_empty = 1'b0; rd_data = 32'hDEAD_BEEF;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); #1;
         check(done && !cmd_en && !wr_en && !rd_en, "R10", "quiet after done",
               {28'd0, done, cmd_en, wr_en, rd_en}, 32'h8);
      end
      if (bad0 >= 0)
         check(err == 1'b1, "R8", "flag sticky while idle", {31'd0, err}, 32'd1);
      if (do_clear) begin
         @(negedge clk);
         err_clear = 1'b1;
         @(negedge clk);
         err_clear = 1'b0;
         #1;
         check(err == 1'b0, "R9", "clear drops flag", {31'd0, err}, 32'd0);
         check(err_addr == 32'd0, "R9", "clear zeroes address", err_addr, 32'd0);
         check(done == 1'b1, "R10", "done survives clear", {31'd0, done}, 32'd1);
      end
      rd_empty = 1'b1;
   endtask

   initial begin
      // sweep every stall combination on the three FIFOs
      for (int cm = 0; cm < 4; cm++)
         for (int wm = 0; wm < 4; wm++)
            for (int rs = 0; rs < 2; rs++)
               run_case(cm, wm, rs, -1, -1, 1'b0);
      // corrupted words: first one must be reported, then cleared
      run_case(0, 0, 0, 5, 9, 1'b1);
      run_case(2, 3, 1, 0, 15, 1'b1);
      run_case(1, 1, 1, 15, -1, 1'b1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule